// File: doc/BRIEF.md
# Sub-dword operand select unit

This block conditions one lane's source operand before it reaches an ALU. From a 32-bit source word it takes one byte, one 16-bit half, or the whole word, and moves that field down to bit 0. It then applies the requested modifiers in a way that depends on the operand's type class. For integers these are sign extension, absolute value and negation in two's complement. For floats, absolute value and negation only change the field's top bit. The result is a 32-bit operand ready for the datapath.

Some modifier combinations make no sense for a type class. Sign extension on a float is one. Negation or sign extension on an unsigned integer is another. Such combinations, an unused select code and the reserved type code all raise an error flag, so the issuing logic can trap the operation. An instance either leaves the block purely combinational or adds one output register.

Top module: `opsel_unit`

## Requirements
- R1: Select codes 0 to 3 pick bytes 0 to 3, code 4 picks bits 15:0 and code 5 picks bits 31:16. The field appears right-justified and zero-extended when the type is unsigned (type code 0) and no modifier is set.
- R2: Select code 6 passes the full 32-bit word through.
- R3: For a signed operand (type code 1), sign extension copies the field's top bit into every bit above the field. Without any modifier the signed field is zero-extended.
- R4: For a signed operand with abs set, a field whose top bit is set is sign-extended and replaced by its 32-bit two's-complement negation. A field with its top bit clear is unchanged. A full word of 0x80000000 stays 0x80000000.
- R5: For a signed operand with neg set, the field is sign-extended and then negated in two's complement. When abs is also set, the negation acts on the absolute value.
- R6: For a float operand (type code 2), abs clears the field's top bit and neg inverts it. Neg acts after abs, so the two together set the top bit.
- R7: An unsigned operand with neg or sign extension set raises the error flag and returns the zero-extended field unmodified. Abs on an unsigned operand has no effect and raises no error.
- R8: A float operand with sign extension set raises the error flag. Sign extension is ignored, while abs and neg still apply.
- R9: Select code 7 raises the error flag and returns the source word unchanged, whatever the modifiers.
- R10: Type code 3 is reserved: it raises the error flag and returns the zero-extended field unmodified.
- R11: Every combination not listed in R7 to R10 leaves the error flag low.
- R12: With the output register enabled (the default), result and error appear one clock after their inputs and are cleared to zero while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Source word |
| sel_i | input | 3 | Field select code |
| tclass_i | input | 2 | Type class: 0 unsigned, 1 signed, 2 float, 3 reserved |
| sext_i | input | 1 | Sign-extension request |
| neg_i | input | 1 | Negate request |
| abs_i | input | 1 | Absolute-value request |
| result_o | output | 32 | Conditioned operand |
| err_o | output | 1 | Illegal select, type or modifier combination |

## Verification
A wrong field position or width shows up as the wrong bits in `result_o` one clock after the select code changes. A lost top-bit indication corrupts only signed or float operands whose field top bit is set. This is why the stimulus mixes sign-set and sign-clear bytes, halves and words. A mistake in the legality decode shows up on `err_o` in the same cycle as the result. The combinations at the boundaries are checked both for the flag and for the value that is passed through.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
   typedef enum logic [1:0] {
      TC_UNSIGNED = 2'd0,
      TC_SIGNED   = 2'd1,
      TC_FLOAT    = 2'd2,
      TC_RESERVED = 2'd3
   } tclass_e;
endpackage

// File: rtl/opsel_field_extract.sv
module opsel_field_extract #(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 3
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [DATA_W-1:0] field_o,
   output logic [DATA_W-1:0] fmask_o,
   output logic [DATA_W-1:0] topbit_o,
   output logic              sign_o,
   output logic              bad_o
);
   localparam int NUM_BYTE = DATA_W / 8;
   localparam int NUM_HALF = DATA_W / 16;
   localparam int NUM_CODE = NUM_BYTE + NUM_HALF + 1;

   logic [DATA_W-1:0] cand_field [NUM_CODE];
   logic [DATA_W-1:0] cand_mask  [NUM_CODE];

   for (genvar b = 0; b < NUM_BYTE; b++) begin : g_byte
      assign cand_field[b] = DATA_W'(src_i[8*b +: 8]);
      assign cand_mask[b]  = DATA_W'({8{1'b1}});
   end

   for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
      assign cand_field[NUM_BYTE+h] = DATA_W'(src_i[16*h +: 16]);
      assign cand_mask[NUM_BYTE+h]  = DATA_W'({16{1'b1}});
   end

   assign cand_field[NUM_CODE-1] = src_i;
   assign cand_mask[NUM_CODE-1]  = '1;

   always_comb begin
      field_o = src_i;
      fmask_o = '1;
      bad_o   = 1'b1;
      for (int i = 0; i < NUM_CODE; i++) begin
         if (sel_i == SEL_W'(i)) begin
            field_o = cand_field[i];
            fmask_o = cand_mask[i];
            bad_o   = 1'b0;
         end
      end
   end

   assign topbit_o = fmask_o ^ (fmask_o >> 1);
   assign sign_o   = |(field_o & topbit_o);

   // R1: exactly one field top bit for every select code
   always_comb begin
      a_r1_one_top_bit: assert ($onehot(topbit_o) || $isunknown(sel_i))
         else $error("field top-bit vector not one-hot");
   end
endmodule

// File: rtl/opsel_modifier.sv
module opsel_modifier
   import opsel_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] field_i,
   input  logic [DATA_W-1:0] fmask_i,
   input  logic [DATA_W-1:0] topbit_i,
   input  logic              sign_i,
   input  logic              bad_sel_i,
   input  logic [DATA_W-1:0] src_i,
   input  tclass_e           tclass_i,
   input  logic              sext_i,
   input  logic              neg_i,
   input  logic              abs_i,
   output logic [DATA_W-1:0] value_o,
   output logic              err_o
);
   logic [DATA_W-1:0] ext_val, int_base, int_mag, int_res;
   logic [DATA_W-1:0] flt_abs, flt_res;

   always_comb begin
      ext_val  = sign_i ? (field_i | ~fmask_i) : field_i;
      int_base = (sext_i || neg_i || (abs_i && sign_i)) ? ext_val : field_i;
      int_mag  = (abs_i && sign_i) ? ('0 - int_base) : int_base;
      int_res  = neg_i ? ('0 - int_mag) : int_mag;
      flt_abs  = abs_i ? (field_i & ~topbit_i) : field_i;
      flt_res  = neg_i ? (flt_abs ^ topbit_i) : flt_abs;
   end

   always_comb begin
      if (bad_sel_i) begin
         value_o = src_i;
         err_o   = 1'b1;
      end else begin
         unique case (tclass_i)
            TC_SIGNED: begin
               value_o = int_res;
               err_o   = 1'b0;
            end
            TC_FLOAT: begin
               value_o = flt_res;
               err_o   = sext_i;
            end
            TC_UNSIGNED: begin
               value_o = field_i;
               err_o   = neg_i | sext_i;
            end
            default: begin
               value_o = field_i;
               err_o   = 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/opsel_out_stage.sv
module opsel_out_stage #(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d_val_i,
   input  logic              d_err_i,
   output logic [DATA_W-1:0] q_val_o,
   output logic              q_err_o
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_val_o <= '0;
            q_err_o <= 1'b0;
         end else begin
            q_val_o <= d_val_i;
            q_err_o <= d_err_i;
         end
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign q_val_o = d_val_i;
      assign q_err_o = d_err_i;
   end
endmodule

// File: rtl/opsel_unit.sv
module opsel_unit
   import opsel_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 3,
   parameter int TC_W    = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [TC_W-1:0]   tclass_i,
   input  logic              sext_i,
   input  logic              neg_i,
   input  logic              abs_i,
   output logic [DATA_W-1:0] result_o,
   output logic              err_o
);
   localparam int NUM_CODE  = DATA_W / 8 + DATA_W / 16 + 1;
   localparam int FULL_CODE = NUM_CODE - 1;

   if (DATA_W < 16 || DATA_W % 16 != 0) begin : g_chk_w
      $error("DATA_W must be a positive multiple of 16");
   end
   if ((1 << SEL_W) < NUM_CODE) begin : g_chk_sel
      $error("SEL_W too narrow for all select codes");
   end
   if (TC_W != $bits(tclass_e)) begin : g_chk_tc
      $error("TC_W must match the type class encoding");
   end

   logic [DATA_W-1:0] field, fmask, topbit, comb_val;
   logic              sign, bad_sel, comb_err;

   opsel_field_extract #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_extract (
      .src_i    (src_i),
      .sel_i    (sel_i),
      .field_o  (field),
      .fmask_o  (fmask),
      .topbit_o (topbit),
      .sign_o   (sign),
      .bad_o    (bad_sel)
   );

   opsel_modifier #(.DATA_W(DATA_W)) u_modify (
      .field_i   (field),
      .fmask_i   (fmask),
      .topbit_i  (topbit),
      .sign_i    (sign),
      .bad_sel_i (bad_sel),
      .src_i     (src_i),
      .tclass_i  (tclass_e'(tclass_i)),
      .sext_i    (sext_i),
      .neg_i     (neg_i),
      .abs_i     (abs_i),
      .value_o   (comb_val),
      .err_o     (comb_err)
   );

   opsel_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_val_i (comb_val),
      .d_err_i (comb_err),
      .q_val_o (result_o),
      .q_err_o (err_o)
   );

   if (OUT_REG) begin : g_props
      a_r9_bad_sel_err: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(sel_i) >= NUM_CODE) |=> err_o);
      a_r9_bad_sel_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(sel_i) >= NUM_CODE) |=> (result_o == $past(src_i)));
      a_r10_reserved_err: assert property (@(posedge clk) disable iff (!rst_n)
         (tclass_i == TC_W'(TC_RESERVED)) |=> err_o);
      a_r7_unsigned_err: assert property (@(posedge clk) disable iff (!rst_n)
         ((tclass_i == TC_W'(TC_UNSIGNED)) && (neg_i || sext_i)) |=> err_o);
      a_r8_float_sext_err: assert property (@(posedge clk) disable iff (!rst_n)
         ((tclass_i == TC_W'(TC_FLOAT)) && sext_i) |=> err_o);
      a_r11_legal_no_err: assert property (@(posedge clk) disable iff (!rst_n)
         ((int'(sel_i) < NUM_CODE) && (tclass_i != TC_W'(TC_RESERVED))
          && !((tclass_i == TC_W'(TC_UNSIGNED)) && (neg_i || sext_i))
          && !((tclass_i == TC_W'(TC_FLOAT)) && sext_i)) |=> !err_o);
      a_r6_float_abs_word: assert property (@(posedge clk) disable iff (!rst_n)
         ((int'(sel_i) == FULL_CODE) && (tclass_i == TC_W'(TC_FLOAT)) && abs_i && !neg_i)
         |=> !result_o[DATA_W-1]);
      a_r1_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
         ((int'(sel_i) < DATA_W / 8) && (tclass_i == TC_W'(TC_UNSIGNED)))
         |=> (result_o[DATA_W-1:8] == '0));
   end
endmodule

// File: tb/opsel_unit_tb.sv
module opsel_unit_tb;
   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  sel;
      logic [1:0]  tc;
      logic [2:0]  mods;   // {sext, neg, abs}
      logic [31:0] src;
      logic [31:0] exp;
      logic        experr;
   } vec_t;

   localparam int NVEC = 35;
   localparam logic [31:0] S = 32'h8A7FC3E5;
   localparam vec_t VECS [NVEC] = '{
      '{4'd1, 3'd0, 2'd0, 3'b000, S, 32'h000000E5, 1'b0},  // R1
      '{4'd1, 3'd1, 2'd0, 3'b000, S, 32'h000000C3, 1'b0},  // R1
      '{4'd1, 3'd2, 2'd0, 3'b000, S, 32'h0000007F, 1'b0},  // R1
      '{4'd1, 3'd3, 2'd0, 3'b000, S, 32'h0000008A, 1'b0},  // R1
      '{4'd1, 3'd4, 2'd0, 3'b000, S, 32'h0000C3E5, 1'b0},  // R1
      '{4'd1, 3'd5, 2'd0, 3'b000, S, 32'h00008A7F, 1'b0},  // R1
      '{4'd2, 3'd6, 2'd0, 3'b000, S, 32'h8A7FC3E5, 1'b0},  // R2
      '{4'd3, 3'd0, 2'd1, 3'b100, S, 32'hFFFFFFE5, 1'b0},  // R3
      '{4'd3, 3'd2, 2'd1, 3'b100, S, 32'h0000007F, 1'b0},  // R3
      '{4'd3, 3'd4, 2'd1, 3'b100, S, 32'hFFFFC3E5, 1'b0},  // R3
      '{4'd3, 3'd1, 2'd1, 3'b000, S, 32'h000000C3, 1'b0},  // R3
      '{4'd4, 3'd0, 2'd1, 3'b001, S, 32'h0000001B, 1'b0},  // R4
      '{4'd4, 3'd2, 2'd1, 3'b001, S, 32'h0000007F, 1'b0},  // R4
      '{4'd4, 3'd5, 2'd1, 3'b001, S, 32'h00007581, 1'b0},  // R4
      '{4'd4, 3'd6, 2'd1, 3'b001, 32'h80000000, 32'h80000000, 1'b0},  // R4
      '{4'd4, 3'd6, 2'd1, 3'b001, S, 32'h75803C1B, 1'b0},  // R4
      '{4'd5, 3'd2, 2'd1, 3'b010, S, 32'hFFFFFF81, 1'b0},  // R5
      '{4'd5, 3'd0, 2'd1, 3'b010, S, 32'h0000001B, 1'b0},  // R5
      '{4'd5, 3'd0, 2'd1, 3'b011, S, 32'hFFFFFFE5, 1'b0},  // R5
      '{4'd5, 3'd6, 2'd1, 3'b010, 32'h00000001, 32'hFFFFFFFF, 1'b0},  // R5
      '{4'd6, 3'd3, 2'd2, 3'b001, S, 32'h0000000A, 1'b0},  // R6
      '{4'd6, 3'd5, 2'd2, 3'b010, S, 32'h00000A7F, 1'b0},  // R6
      '{4'd6, 3'd4, 2'd2, 3'b010, S, 32'h000043E5, 1'b0},  // R6
      '{4'd6, 3'd2, 2'd2, 3'b010, S, 32'h000000FF, 1'b0},  // R6
      '{4'd6, 3'd6, 2'd2, 3'b011, 32'h0A7FC3E5, 32'h8A7FC3E5, 1'b0},  // R6
      '{4'd6, 3'd6, 2'd2, 3'b001, S, 32'h0A7FC3E5, 1'b0},  // R6
      '{4'd7, 3'd0, 2'd0, 3'b010, S, 32'h000000E5, 1'b1},  // R7
      '{4'd7, 3'd4, 2'd0, 3'b100, S, 32'h0000C3E5, 1'b1},  // R7
      '{4'd7, 3'd3, 2'd0, 3'b001, S, 32'h0000008A, 1'b0},  // R7
      '{4'd8, 3'd0, 2'd2, 3'b100, S, 32'h000000E5, 1'b1},  // R8
      '{4'd8, 3'd5, 2'd2, 3'b110, S, 32'h00000A7F, 1'b1},  // R8
      '{4'd9, 3'd7, 2'd1, 3'b111, S, 32'h8A7FC3E5, 1'b1},  // R9
      '{4'd9, 3'd7, 2'd0, 3'b000, S, 32'h8A7FC3E5, 1'b1},  // R9
      '{4'd10, 3'd0, 2'd3, 3'b001, S, 32'h000000E5, 1'b1}, // R10
      '{4'd10, 3'd6, 2'd3, 3'b010, S, 32'h8A7FC3E5, 1'b1}  // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic [2:0]  sel = '0;
   logic [1:0]  tcls = '0;
   logic        sext = 1'b0, neg = 1'b0, absf = 1'b0;
   logic [31:0] result;
   logic        err;
   int          n_checks = 0;
   int          n_fail = 0;

   always #5 clk = ~clk;

   opsel_unit u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src),
      .sel_i    (sel),
      .tclass_i (tcls),
      .sext_i   (sext),
      .neg_i    (neg),
      .abs_i    (absf),
      .result_o (result),
      .err_o    (err)
   );

   task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s result: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_err(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s error flag: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] s, input logic [1:0] t, input logic [2:0] m,
                        input logic [31:0] d);
      sel  = s;
      tcls = t;
      {sext, neg, absf} = m;
      src  = d;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check_val("R12 reset", result, 32'h0);
      check_err("R12 reset", err, 1'b0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VECS[i].sel, VECS[i].tc, VECS[i].mods, VECS[i].src);
         @(posedge clk);
         #2;
         check_val($sformatf("R%0d vec %0d", VECS[i].req, i), result, VECS[i].exp);
         check_err($sformatf("R%0d vec %0d", VECS[i].req, i), err, VECS[i].experr);
      end

      // R11: all three modifiers on a signed half word are legal
      @(negedge clk);
      drive(3'd4, 2'd1, 3'b111, S);
      @(posedge clk);
      #2;
      check_val("R11 signed all modifiers", result, 32'hFFFFC3E5);
      check_err("R11 signed all modifiers", err, 1'b0);

      // R12: one-cycle latency, old value held until the edge
      @(negedge clk);
      drive(3'd0, 2'd0, 3'b000, 32'h00000011);
      #2;
      check_val("R12 before edge", result, 32'hFFFFC3E5);
      @(posedge clk);
      #2;
      check_val("R12 after edge", result, 32'h00000011);

      // R12: asynchronous clear while running
      @(negedge clk);
      drive(3'd7, 2'd3, 3'b111, S);
      @(posedge clk);
      #2;
      check_err("R12 error before reset", err, 1'b1);
      rst_n = 1'b0;
      #1;
      check_val("R12 async reset", result, 32'h0);
      check_err("R12 async reset", err, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #100000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule